// File: doc/BRIEF.md
# Bit-Serial Speech Memory Controller

This block keeps a one-bit speech stream in external dynamic RAM. A codec core hands it one data bit per audio bit period, either to store or to fetch. The block turns each such request into a complete DRAM cycle: row address and row strobe, then column address and column strobe, with the write-enable line held low for stores. It keeps the memory alive with CAS-before-RAS refresh cycles, paced so that all rows are covered in time even at half the nominal clock. It also produces the audio bit-rate strobe that paces the codec, at one of two rates.

A controller loads a starting bit address. Each completed access then advances the address by one, so a message plays out or records as a contiguous run of bits. A mode input picks the memory arrangement. With one 4 Mbit device, the shared pin carries the eleventh address line. With two 1 Mbit devices, the same pin becomes the row strobe of the second device, and address bit 20 chooses the device.

Top module: `spdram_ctrl`

## Requirements
- R1: `bit_tick` is a one-clock pulse. Its period is 125 clocks when `rate_fast` is 0 and 63 clocks when `rate_fast` is 1.
- R2: With `mode_4m`=1, bit address [21:11] is the row and [10:0] is the column. Bits [9:0] of each go on `dram_a`, and bit 10 goes on `dram_a10_ras2_n`. Every access uses `dram_ras_n`.
- R3: With `mode_4m`=0, address bit 20 picks the device, [19:10] is the row and [9:0] is the column, all on `dram_a`. Device 0 is strobed by `dram_ras_n` and device 1 by `dram_a10_ras2_n` (active low). During an access exactly one of the two is low.
- R4: A `start_load` pulse sets the bit address to `start_addr`. Each access advances it by one. The address wraps modulo 2^22 with `mode_4m`=1 and modulo 2^21 with `mode_4m`=0; in the second mode bit 21 of a loaded value is dropped.
- R5: For each access the row address is on `dram_a` at least one clock before its row strobe falls, and the column address is there at least one clock before `dram_cas_n` falls. `dram_we_n` is low from before the row strobe until the end of CAS for a write, and high for a read.
- R6: A write drives `acc_wdata` onto `dram_dq` while CAS is low. A read samples `dram_dq` while CAS is low and presents it on `acc_rdata` together with a one-clock `acc_ack` pulse. Both kinds of access end with that pulse.
- R7: A refresh lowers `dram_cas_n` at least one clock before the row strobe, with `dram_we_n` high. With `mode_4m`=0, both row strobes are lowered.
- R8: A refresh is requested every REF_INT clocks. REF_INT is 15 by default: 8 ms at 2 MHz divided by 1024 rows.
- R9: A pending refresh is served before a pending access. An access request is still acknowledged within 12 clocks, well inside one bit period.
- R10: While reset is asserted, all strobes are high, `dram_a10_ras2_n` is high with `mode_4m`=0, and `acc_ack` and `bit_tick` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 4 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_4m | input | 1 | 1: one 4 Mbit device, 0: two 1 Mbit devices |
| rate_fast | input | 1 | Bit-rate select: 1 for 63-clock periods, 0 for 125 |
| start_load | input | 1 | Load pulse for the bit address |
| start_addr | input | 22 | Bit address to load |
| bit_tick | output | 1 | Audio bit-period strobe |
| acc_req | input | 1 | Access request pulse from the codec |
| acc_wr | input | 1 | 1 for a store, 0 for a fetch |
| acc_wdata | input | 1 | Bit to store |
| acc_ack | output | 1 | Access complete pulse |
| acc_rdata | output | 1 | Fetched bit |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_a10_ras2_n | output | 1 | Address bit 10, or the second device's row strobe |
| dram_ras_n | output | 1 | Row strobe, single or first device |
| dram_cas_n | output | 1 | Column strobe, shared |
| dram_we_n | output | 1 | Write enable, shared |
| dram_dq | inout | 1 | Bidirectional data line |

## Verification
A sequencer stuck in or skipping a state shows up within a few clocks: a strobe falls without the one-clock address setup, CAS and RAS fall in the wrong order, or `acc_ack` is missing within 12 clocks. A stale or wrongly masked address counter is seen on the very next access, because the location strobed onto the pins differs from the one predicted from the loaded address. A wrong device-select decode appears at the first access past the device boundary as the wrong strobe or as two strobes together. A refresh timer off by a clock shows up as a drift in the refresh count over a long idle window.

// File: rtl/spdram_pkg.sv
package spdram_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_RF_HOLD,
    ST_RF_END,
    ST_AC_ROW,
    ST_AC_RAS,
    ST_AC_COL,
    ST_AC_CAS,
    ST_AC_PRE
  } seq_st_e;

  typedef struct packed {
    logic ras_n;
    logic ras2_n;
    logic cas_n;
    logic we_n;
    logic col_sel;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PIN_CTL_IDLE = '{ras_n: 1'b1, ras2_n: 1'b1, cas_n: 1'b1,
                                        we_n: 1'b1, col_sel: 1'b0, dq_oe: 1'b0};

endpackage

// File: rtl/spdram_bitclk.sv
module spdram_bitclk #(
  parameter int PER_SLOW = 125,
  parameter int PER_FAST = 63
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_fast,
  output logic tick
);
  localparam int CW = $clog2(PER_SLOW + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          tick_q, tick_d;

  always_comb begin
    lim    = rate_fast ? CW'(PER_FAST - 1) : CW'(PER_SLOW - 1);
    tick_d = (cnt_q >= lim);
    cnt_d  = tick_d ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

endmodule

// File: rtl/spdram_refresh.sv
module spdram_refresh #(
  parameter int REF_INT  = 15,
  parameter int MAX_WAIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_go,
  output logic ref_pend
);
  localparam int CW = $clog2(REF_INT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap, pend_q, pend_d;
  logic [3:0]    age_q;

  always_comb begin
    wrap   = (cnt_q == CW'(REF_INT - 1));
    cnt_d  = wrap ? '0 : cnt_q + CW'(1);
    pend_d = wrap | (pend_q & ~ref_go);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign ref_pend = pend_q;

  // cycles a refresh request has been waiting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 age_q <= '0;
    else if (pend_q && !ref_go) age_q <= age_q + 4'd1;
    else                        age_q <= '0;
  end

  a_r9_refresh_wait: assert property (@(posedge clk) disable iff (!rst_n)
    age_q < 4'(MAX_WAIT));

endmodule

// File: rtl/spdram_addr.sv
module spdram_addr #(
  parameter int ADDR_W = 22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_4m,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     load_val,
  input  logic                  adv,
  input  logic                  col_sel,
  output logic [ADDR_W/2-1:0]   pin_field,
  output logic                  bank_hi
);
  localparam int ROW_W = ADDR_W / 2;

  logic [ADDR_W-1:0] cur_q, cur_d, inc;
  logic [ROW_W-1:0]  row_f, col_f;

  function automatic logic [ADDR_W-1:0] fit(input logic [ADDR_W-1:0] v, input logic big);
    return big ? v : {1'b0, v[ADDR_W-2:0]};
  endfunction

  always_comb begin
    inc   = cur_q + ADDR_W'(1);
    cur_d = cur_q;
    if (load)     cur_d = fit(load_val, mode_4m);
    else if (adv) cur_d = fit(inc, mode_4m);
    if (mode_4m) begin
      row_f = cur_q[ADDR_W-1:ROW_W];
      col_f = cur_q[ROW_W-1:0];
    end else begin
      row_f = {1'b0, cur_q[ADDR_W-3:ROW_W-1]};
      col_f = {1'b0, cur_q[ROW_W-2:0]};
    end
    pin_field = col_sel ? col_f : row_f;
    bank_hi   = cur_q[ADDR_W-2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

endmodule

// File: rtl/spdram_seq.sv
module spdram_seq
  import spdram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_4m,
  input  logic ref_pend,
  input  logic acc_req,
  input  logic acc_wr,
  input  logic acc_wdata,
  input  logic bank_hi,
  input  logic dq_in,
  output logic ref_go,
  output logic adv,
  output logic col_sel,
  output logic ras_n,
  output logic ras2_n,
  output logic cas_n,
  output logic we_n,
  output logic dq_oe,
  output logic dq_o,
  output logic acc_ack,
  output logic acc_rdata
);
  seq_st_e  st_q, st_d;
  pin_ctl_t ctl_q, ctl_d;
  logic     pend_q, pend_d, wr_q, wr_d, wd_q, wd_d;
  logic     rd_q, rd_d, ack_q, ack_d;
  logic     busy, start, accept, acc_ras_n, acc_ras2_n;
  logic [3:0] wait_q;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (ref_pend) st_d = ST_RF_CAS;
                  else if (pend_q) st_d = ST_AC_ROW;
      ST_RF_CAS:  st_d = ST_RF_RAS;
      ST_RF_RAS:  st_d = ST_RF_HOLD;
      ST_RF_HOLD: st_d = ST_RF_END;
      ST_RF_END:  st_d = pend_q ? ST_AC_ROW : ST_IDLE;
      ST_AC_ROW:  st_d = ST_AC_RAS;
      ST_AC_RAS:  st_d = ST_AC_COL;
      ST_AC_COL:  st_d = ST_AC_CAS;
      ST_AC_CAS:  st_d = ST_AC_PRE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // request slot, data path, pin controls
  always_comb begin
    busy   = st_q inside {ST_AC_ROW, ST_AC_RAS, ST_AC_COL, ST_AC_CAS, ST_AC_PRE};
    start  = (st_d == ST_AC_ROW) && (st_q != ST_AC_ROW);
    accept = acc_req && !pend_q && !busy;
    pend_d = start ? 1'b0 : (accept ? 1'b1 : pend_q);
    wr_d   = accept ? acc_wr : wr_q;
    wd_d   = accept ? acc_wdata : wd_q;
    ref_go = (st_q == ST_IDLE) && ref_pend;
    adv    = (st_q == ST_AC_CAS);
    ack_d  = (st_d == ST_AC_PRE);
    rd_d   = (st_q == ST_AC_CAS && !wr_q) ? dq_in : rd_q;

    acc_ras_n  = !(mode_4m || !bank_hi);
    acc_ras2_n = !(!mode_4m && bank_hi);

    ctl_d = PIN_CTL_IDLE;
    case (st_d)
      ST_RF_CAS: ctl_d.cas_n = 1'b0;
      ST_RF_RAS, ST_RF_HOLD: begin
        ctl_d.cas_n  = 1'b0;
        ctl_d.ras_n  = 1'b0;
        ctl_d.ras2_n = mode_4m;
      end
      ST_AC_ROW: begin
        ctl_d.we_n  = !wr_q;
        ctl_d.dq_oe = wr_q;
      end
      ST_AC_RAS: begin
        ctl_d.we_n   = !wr_q;
        ctl_d.dq_oe  = wr_q;
        ctl_d.ras_n  = acc_ras_n;
        ctl_d.ras2_n = acc_ras2_n;
      end
      ST_AC_COL, ST_AC_CAS: begin
        ctl_d.we_n    = !wr_q;
        ctl_d.dq_oe   = wr_q;
        ctl_d.ras_n   = acc_ras_n;
        ctl_d.ras2_n  = acc_ras2_n;
        ctl_d.col_sel = 1'b1;
        ctl_d.cas_n   = (st_d != ST_AC_CAS);
      end
      default: ctl_d = PIN_CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ctl_q  <= PIN_CTL_IDLE;
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
      wd_q   <= 1'b0;
      rd_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      pend_q <= pend_d;
      wr_q   <= wr_d;
      wd_q   <= wd_d;
      rd_q   <= rd_d;
      ack_q  <= ack_d;
    end
  end

  assign ras_n     = ctl_q.ras_n;
  assign ras2_n    = ctl_q.ras2_n;
  assign cas_n     = ctl_q.cas_n;
  assign we_n      = ctl_q.we_n;
  assign col_sel   = ctl_q.col_sel;
  assign dq_oe     = ctl_q.dq_oe;
  assign dq_o      = wd_q;
  assign acc_ack   = ack_q;
  assign acc_rdata = rd_q;

  // cycles an accepted request has waited to start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wait_q <= '0;
    else if (pend_q) wait_q <= wait_q + 4'd1;
    else             wait_q <= '0;
  end

  a_r9_access_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q < 4'd8);

  a_r7_cas_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  a_r5_we_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !we_n) |-> $past(!we_n));

  a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !ras2_n) |-> $past(!cas_n));

  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ack |=> !acc_ack);

endmodule

// File: rtl/spdram_ctrl.sv
module spdram_ctrl #(
  parameter int ADDR_W        = 22,
  parameter int CLK_MIN_KHZ   = 2000,
  parameter int REF_WINDOW_MS = 8,
  parameter int REF_ROWS      = 1024,
  parameter int PER_SLOW      = 125,
  parameter int PER_FAST      = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_4m,
  input  logic              rate_fast,
  input  logic              start_load,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              bit_tick,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic              acc_wdata,
  output logic              acc_ack,
  output logic              acc_rdata,
  output logic [ADDR_W/2-2:0] dram_a,
  output logic              dram_a10_ras2_n,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  inout  wire               dram_dq
);
  localparam int ROW_W   = ADDR_W / 2;
  localparam int PIN_W   = ROW_W - 1;
  localparam int REF_INT = CLK_MIN_KHZ * REF_WINDOW_MS / REF_ROWS;

  logic [1:0]       rsync_q;
  logic             rst_i_n;
  logic             ref_pend, ref_go, adv, col_sel, bank_hi;
  logic             ras2_n, dq_oe, dq_o;
  logic [ROW_W-1:0] pin_field;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  spdram_bitclk #(.PER_SLOW(PER_SLOW), .PER_FAST(PER_FAST)) u_bitclk (
    .clk(clk), .rst_n(rst_i_n), .rate_fast(rate_fast), .tick(bit_tick));

  spdram_refresh #(.REF_INT(REF_INT), .MAX_WAIT(10)) u_refresh (
    .clk(clk), .rst_n(rst_i_n), .ref_go(ref_go), .ref_pend(ref_pend));

  spdram_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_i_n), .mode_4m(mode_4m), .load(start_load),
    .load_val(start_addr), .adv(adv), .col_sel(col_sel),
    .pin_field(pin_field), .bank_hi(bank_hi));

  spdram_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .mode_4m(mode_4m), .ref_pend(ref_pend),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .bank_hi(bank_hi), .dq_in(dram_dq), .ref_go(ref_go), .adv(adv),
    .col_sel(col_sel), .ras_n(dram_ras_n), .ras2_n(ras2_n),
    .cas_n(dram_cas_n), .we_n(dram_we_n), .dq_oe(dq_oe), .dq_o(dq_o),
    .acc_ack(acc_ack), .acc_rdata(acc_rdata));

  assign dram_a          = pin_field[PIN_W-1:0];
  assign dram_a10_ras2_n = mode_4m ? pin_field[PIN_W] : ras2_n;
  assign dram_dq         = dq_oe ? dq_o : 1'bz;

  a_r5_row_setup: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($fell(dram_ras_n) && dram_cas_n) |-> $stable(dram_a));

  a_r5_col_setup: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($fell(dram_cas_n) && (!dram_ras_n || !ras2_n)) |-> $stable(dram_a));

endmodule

// File: tb/sim_spdram_ctrl.sv
`timescale 1ns/1ps
module sim_spdram_ctrl;
  logic clk = 1'b0;
  logic rst_n, mode4, rate_fast, start_load, acc_req, acc_wr, acc_wdata;
  logic [21:0] start_addr;
  logic bit_tick, acc_ack, acc_rdata, p10, ras_n, cas_n, we_n;
  logic [9:0] dram_a;
  wire  dram_dq;
  logic m_oe, m_d;

  always #2.5 clk = ~clk;

  spdram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_4m(mode4), .rate_fast(rate_fast),
    .start_load(start_load), .start_addr(start_addr), .bit_tick(bit_tick),
    .acc_req(acc_req), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
    .acc_ack(acc_ack), .acc_rdata(acc_rdata), .dram_a(dram_a),
    .dram_a10_ras2_n(p10), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_dq(dram_dq));

  assign dram_dq = m_oe ? m_d : 1'bz;

  typedef struct { int key; bit wr; bit d; } exp_t;
  exp_t sbq[$];
  bit   mem[int];
  bit   shadow[int];
  int   n_chk = 0, n_bad = 0, ref_cnt = 0;
  bit   done = 0;
  logic [21:0] exp_addr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int key_of(input logic [21:0] a, input bit m4);
    if (m4) return int'(a);
    return 32'h0040_0000 | int'(a[20:0]);
  endfunction

  // DRAM model and scoreboard monitor, sampling at falling clock edges
  logic prev_ras, prev_cas, prev_s2, prev_p10, we_at_ras, in_acc, bank;
  logic [9:0]  prev_a;
  logic [10:0] row;
  int cur_key;
  always @(negedge clk) begin
    logic s2;
    logic [10:0] col;
    int key;
    exp_t e;
    if (!rst_n) begin
      prev_ras = 1; prev_cas = 1; prev_s2 = 1; prev_p10 = 1; prev_a = '0;
      in_acc = 0; m_oe = 0; m_d = 0; we_at_ras = 1; bank = 0; row = '0; cur_key = 0;
    end else begin
      s2 = mode4 ? 1'b1 : p10;
      if (cas_n && ((prev_ras && !ras_n) || (prev_s2 && !s2))) begin
        in_acc = 1;
        bank = prev_s2 && !s2;
        row = mode4 ? {p10, dram_a} : {1'b0, dram_a};
        we_at_ras = we_n;
        chk(dram_a == prev_a && (!mode4 || p10 == prev_p10), "R5 row address setup", dram_a, prev_a);
      end
      if (!cas_n && prev_ras && !ras_n) begin
        ref_cnt++;
        chk(!prev_cas, "R7 CAS low before RAS", prev_cas, 0);
        chk(we_n, "R7 WE high in refresh", we_n, 1);
        if (!mode4) chk(!s2, "R7 second strobe in refresh", s2, 0);
      end
      if (prev_cas && !cas_n && in_acc) begin
        chk(dram_a == prev_a && (!mode4 || p10 == prev_p10), "R5 column address setup", dram_a, prev_a);
        col = mode4 ? {p10, dram_a} : {1'b0, dram_a};
        if (mode4) begin
          key = int'({row, col});
          chk(!ras_n, "R2 main RAS used", ras_n, 0);
        end else begin
          key = 32'h0040_0000 | int'({bank, row[9:0], col[9:0]});
          chk(ras_n ^ s2, "R3 exactly one row strobe", {ras_n, s2}, 1);
        end
        if (sbq.size() == 0) chk(0, "R4 unexpected access", key, -1);
        else begin
          e = sbq.pop_front();
          chk(key == e.key, mode4 ? "R2 R4 location" : "R3 R4 location", key, e.key);
          chk((!we_n) == e.wr && we_at_ras == we_n, "R5 write enable level", we_n, !e.wr);
          if (e.wr) begin
            chk(dram_dq === e.d, "R6 write data on line", dram_dq, e.d);
            mem[key] = dram_dq;
          end
        end
        cur_key = key;
      end
      if (cas_n && ras_n && s2) in_acc = 0;
      m_oe = in_acc && !cas_n && we_n;
      m_d  = mem.exists(cur_key) ? mem[cur_key] : 1'b0;
      prev_ras = ras_n; prev_cas = cas_n; prev_s2 = s2; prev_p10 = p10; prev_a = dram_a;
    end
  end

  task automatic load(input logic [21:0] v);
    @(negedge clk); start_load = 1; start_addr = v;
    @(negedge clk); start_load = 0;
    exp_addr = mode4 ? v : {1'b0, v[20:0]};
  endtask

  // driver: push the expected access, issue it, then check completion
  task automatic do_acc(input bit wr, input bit d);
    exp_t e;
    int lat;
    bit expv;
    e.key = key_of(exp_addr, mode4); e.wr = wr; e.d = d;
    sbq.push_back(e);
    @(negedge clk); acc_req = 1; acc_wr = wr; acc_wdata = d;
    @(negedge clk); acc_req = 0; lat = 1;
    while (!acc_ack && lat < 40) begin @(negedge clk); lat++; end
    chk(acc_ack && lat <= 12, "R9 access acknowledged in time", lat, 12);
    if (!wr) begin
      expv = shadow.exists(e.key) ? shadow[e.key] : 1'b0;
      chk(acc_rdata == expv, "R6 read data", acc_rdata, expv);
    end else shadow[e.key] = d;
    @(negedge clk);
    chk(!acc_ack, "R6 ack single pulse", acc_ack, 0);
    exp_addr = mode4 ? exp_addr + 22'd1 : {1'b0, exp_addr[20:0] + 21'd1};
  endtask

  task automatic measure_tick(input int expv, input string tag);
    int n;
    do @(negedge clk); while (!bit_tick);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_tick);
    chk(n == expv, tag, n, expv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode4 = 0; rate_fast = 0; start_load = 0; start_addr = '0;
    acc_req = 0; acc_wr = 0; acc_wdata = 0; exp_addr = '0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(ras_n && cas_n && we_n, "R10 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(p10, "R10 second row strobe high in reset", p10, 1);
    chk(!acc_ack, "R10 ack low in reset", acc_ack, 0);
    chk(!bit_tick, "R10 tick low in reset", bit_tick, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 bit period at both rates
    measure_tick(125, "R1 slow bit period");
    rate_fast = 1;
    measure_tick(63, "R1 fast bit period (settle)");
    measure_tick(63, "R1 fast bit period");

    // R2 R4 single device: column carry into the next row, then readback
    mode4 = 1;
    load(22'h0007FE);
    do_acc(1, 1); do_acc(1, 0); do_acc(1, 1); do_acc(1, 1);
    load(22'h0007FE);
    for (int i = 0; i < 4; i++) do_acc(0, 0);
    // R4 wrap at the top of the 22-bit space
    load(22'h3FFFFF);
    do_acc(1, 0); do_acc(1, 1);
    load(22'h3FFFFF);
    do_acc(0, 0); do_acc(0, 0);

    // R3 R4 two devices: cross from device 0 to device 1
    mode4 = 0;
    load(22'h0FFFFE);
    do_acc(1, 1); do_acc(1, 1); do_acc(1, 0); do_acc(1, 1);
    load(22'h0FFFFE);
    for (int i = 0; i < 4; i++) do_acc(0, 0);
    // R4 wrap at 2^21 back into device 0
    load(22'h1FFFFF);
    do_acc(1, 1); do_acc(1, 0);
    load(22'h1FFFFF);
    do_acc(0, 0); do_acc(0, 0);
    // R4 bit 21 of a loaded value is dropped in two-device mode
    load(22'h2FFFFE);
    do_acc(0, 0);

    // R8 refresh rate over an idle window
    repeat (20) @(negedge clk);
    ref_cnt = 0;
    repeat (1500) @(negedge clk);
    chk(ref_cnt >= 99 && ref_cnt <= 101, "R8 refresh count in window", ref_cnt, 100);
    chk(sbq.size() == 0, "R4 no missing accesses", sbq.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule